// File: doc/BRIEF.md
# BCD Disk Address Translator

This block sits between a fixed-head disk controller's register interface and its transfer engine. Software names a disk position as a packed-BCD word holding a track number and a sector number. The controller counts in linear word addresses. The translator converts in both directions and holds the current linear address.

A load request presents an address word. The block checks every BCD digit and both ranges. If the word is valid, the held linear address becomes the first word of that sector and the illegal-address flag clears. If the word is invalid, the flag sets and the held address stays as it was. Either way a one-cycle `done` pulse follows.

A read request starts an iterative engine. It peels whole tracks and then whole sectors off the held address, counting both directly in BCD, and then presents the re-encoded word. The geometry is 64 words per sector, 80 sectors per track and 200 tracks, and all of it is set by parameters.

Top module: `dax_xlate`

## Requirements
- R1: After reset, `lin_addr`, `bcd_word`, `busy`, `done` and `ill_addr` are all zero.
- R2: An accepted load with valid fields sets `lin_addr` to ((track × 80) + sector) × 64 and clears `ill_addr`, both visible one clock after acceptance together with `done`. The track is packed BCD in bits 16:8 (bits 11:8 units, 15:12 tens, bit 16 hundreds). The sector is packed BCD in bits 7:0 (bits 3:0 units, 7:4 tens).
- R3: A load whose track or sector field holds any nibble of 10 or more sets `ill_addr` and leaves `lin_addr` unchanged.
- R4: A load with a track of 200 or more, or a sector of 80 or more, sets `ill_addr` and leaves `lin_addr` unchanged.
- R5: Bit 17 of `load_word` has no effect on a load.
- R6: A read returns `bcd_word` = BCD(track) shifted left by 8, ORed with BCD(sector). Here track = `lin_addr` / 5120 and sector = (`lin_addr` mod 5120) / 64, and bit 17 is zero. Each BCD digit uses the nibble layout of R2.
- R7: For a held address at track t and sector s, `done` for a read appears after the (t+s+3)th rising edge, counting the accepting edge as the first. `busy` is high from the accepting edge until `done`.
- R8: While `busy` is high, load and read requests are ignored: `lin_addr` does not change and no extra `done` pulse appears.
- R9: A load and a read requested in the same idle cycle perform the load only; `busy` stays low.
- R10: `done` is high for exactly one cycle per completed operation, and a read does not change `ill_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Request to load an address word |
| load_word | input | 18 | BCD track/sector word for a load |
| read_req | input | 1 | Request to re-encode the held address |
| busy | output | 1 | Read conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| ill_addr | output | 1 | Outcome of the last load: 1 means illegal address |
| lin_addr | output | 20 | Held linear word address |
| bcd_word | output | 18 | Result of the last read |

## Verification
The bench sweeps every 9-bit track code against a spread of sector codes, and every 8-bit sector code against a spread of track codes. It compares each load with arithmetic decoding. A design that only checked ranges would take codes such as 0x0A0 as address 100. A design that updated on an illegal load would lose the held address.

Reads run at every track, each with its own sector. These expose a BCD counter that fails to carry from 9 to 10, and a phase change that is one cycle late or early.

Further tests drive a load and a read in the same cycle, and send requests while busy. A design with the wrong priority, or one that let a request through while busy, would start a read or change `lin_addr`.

// File: rtl/dax_pkg.sv
package dax_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TRK  = 2'd1,
    PH_SEC  = 2'd2
  } phase_t;

  function automatic int unsigned ndigits(input int unsigned field_w);
    return (field_w + 3) / 4;
  endfunction
endpackage

// File: rtl/dax_bcd_decode.sv
module dax_bcd_decode #(
  parameter int FIELD_W = 8,
  parameter int VAL_W   = 8
) (
  input  logic [FIELD_W-1:0] code,
  output logic [VAL_W-1:0]   value,
  output logic               digits_ok
);
  localparam int NDIG = dax_pkg::ndigits(FIELD_W);

  logic [4*NDIG-1:0]  padded;
  logic [NDIG-1:0]    dig_ok;
  logic [VAL_W-1:0]   dig_val [NDIG];

  assign padded = (4*NDIG)'(code);

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    localparam int unsigned WEIGHT = 10 ** g;
    assign dig_ok[g]  = (padded[4*g +: 4] < 4'd10);
    assign dig_val[g] = VAL_W'(padded[4*g +: 4]) * VAL_W'(WEIGHT);
  end

  always_comb begin
    value = '0;
    for (int i = 0; i < NDIG; i++) value = value + dig_val[i];
  end

  assign digits_ok = &dig_ok;
endmodule

// File: rtl/dax_load_unit.sv
module dax_load_unit #(
  parameter int WPS     = 64,
  parameter int SPT     = 80,
  parameter int NTRK    = 200,
  parameter int TRK_W   = 9,
  parameter int SEC_W   = 8,
  parameter int ADDR_W  = 20
) (
  input  logic [TRK_W-1:0]  trk_code,
  input  logic [SEC_W-1:0]  sec_code,
  output logic              ok,
  output logic [ADDR_W-1:0] lin
);
  localparam int TV_W = 4 * dax_pkg::ndigits(TRK_W);
  localparam int SV_W = 4 * dax_pkg::ndigits(SEC_W);

  logic [TV_W-1:0] trk_val;
  logic [SV_W-1:0] sec_val;
  logic            trk_dig_ok, sec_dig_ok;

  dax_bcd_decode #(.FIELD_W(TRK_W), .VAL_W(TV_W)) u_trk (
    .code(trk_code), .value(trk_val), .digits_ok(trk_dig_ok));
  dax_bcd_decode #(.FIELD_W(SEC_W), .VAL_W(SV_W)) u_sec (
    .code(sec_code), .value(sec_val), .digits_ok(sec_dig_ok));

  assign ok = trk_dig_ok && sec_dig_ok &&
              (trk_val < TV_W'(NTRK)) && (sec_val < SV_W'(SPT));

  assign lin = ((ADDR_W'(trk_val) * ADDR_W'(SPT)) + ADDR_W'(sec_val)) * ADDR_W'(WPS);
endmodule

// File: rtl/dax_bcd_counter.sv
module dax_bcd_counter #(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               inc,
  output logic [FIELD_W-1:0] q
);
  localparam int NDIG = dax_pkg::ndigits(FIELD_W);

  logic [3:0]      dig [NDIG];
  logic [NDIG:0]   carry;
  logic [4*NDIG-1:0] flat;

  assign carry[0] = inc;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    assign carry[g+1]      = carry[g] && (dig[g] == 4'd9);
    assign flat[4*g +: 4]  = dig[g];

    always_ff @(posedge clk) begin
      if (rst || clr)    dig[g] <= 4'd0;
      else if (carry[g]) dig[g] <= (dig[g] == 4'd9) ? 4'd0 : dig[g] + 4'd1;
    end

    p_digit_range_r6: assert property (@(posedge clk) disable iff (rst)
      dig[g] <= 4'd9);
  end

  logic unused_carry;
  assign unused_carry = carry[NDIG] ^ (^flat);
  assign q = flat[FIELD_W-1:0];
endmodule

// File: rtl/dax_xlate.sv
module dax_xlate #(
  parameter int WPS    = 64,
  parameter int SPT    = 80,
  parameter int NTRK   = 200,
  parameter int TRK_W  = 9,
  parameter int SEC_W  = 8,
  parameter int WORD_W = 18,
  parameter int ADDR_W = $clog2(NTRK * SPT * WPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  input  logic [WORD_W-1:0] load_word,
  input  logic              read_req,
  output logic              busy,
  output logic              done,
  output logic              ill_addr,
  output logic [ADDR_W-1:0] lin_addr,
  output logic [WORD_W-1:0] bcd_word
);
  import dax_pkg::*;

  localparam int WPT     = WPS * SPT;
  localparam int TRK_LSB = SEC_W;

  phase_t            phase;
  logic [ADDR_W-1:0] rem;
  logic              ld_ok;
  logic [ADDR_W-1:0] ld_lin;
  logic              idle, acc_load, acc_read, trk_step, sec_step;
  logic [TRK_W-1:0]  trk_bcd;
  logic [SEC_W-1:0]  sec_bcd;
  logic [WORD_W-1:0] word_next;

  logic unused_hi;
  assign unused_hi = ^load_word[WORD_W-1:TRK_LSB+TRK_W];

  dax_load_unit #(.WPS(WPS), .SPT(SPT), .NTRK(NTRK), .TRK_W(TRK_W),
                  .SEC_W(SEC_W), .ADDR_W(ADDR_W)) u_load (
    .trk_code(load_word[TRK_LSB +: TRK_W]),
    .sec_code(load_word[SEC_W-1:0]),
    .ok(ld_ok), .lin(ld_lin));

  assign idle     = (phase == PH_IDLE);
  assign acc_load = idle && load_req;
  assign acc_read = idle && read_req && !load_req;
  assign trk_step = (phase == PH_TRK) && (rem >= ADDR_W'(WPT));
  assign sec_step = (phase == PH_SEC) && (rem >= ADDR_W'(WPS));

  dax_bcd_counter #(.FIELD_W(TRK_W)) u_trk_cnt (
    .clk(clk), .rst(rst), .clr(acc_read), .inc(trk_step), .q(trk_bcd));
  dax_bcd_counter #(.FIELD_W(SEC_W)) u_sec_cnt (
    .clk(clk), .rst(rst), .clr(acc_read), .inc(sec_step), .q(sec_bcd));

  always_comb begin
    word_next = '0;
    word_next[TRK_LSB +: TRK_W] = trk_bcd;
    word_next[SEC_W-1:0]        = sec_bcd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      rem      <= '0;
      done     <= 1'b0;
      ill_addr <= 1'b0;
      lin_addr <= '0;
      bcd_word <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (acc_load) begin
            done     <= 1'b1;
            ill_addr <= !ld_ok;
            if (ld_ok) lin_addr <= ld_lin;
          end else if (acc_read) begin
            rem   <= lin_addr;
            phase <= PH_TRK;
          end
        end
        PH_TRK: begin
          if (trk_step) rem <= rem - ADDR_W'(WPT);
          else          phase <= PH_SEC;
        end
        PH_SEC: begin
          if (sec_step) rem <= rem - ADDR_W'(WPS);
          else begin
            phase    <= PH_IDLE;
            done     <= 1'b1;
            bcd_word <= word_next;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = !idle;

  p_good_load_r2: assert property (@(posedge clk) disable iff (rst)
    (idle && load_req && ld_ok) |=> (done && !ill_addr && lin_addr == $past(ld_lin)));
  p_bad_load_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (idle && load_req && !ld_ok) |=> (done && ill_addr && $stable(lin_addr)));
  p_sec_below_track_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SEC) |-> (rem < ADDR_W'(WPT)));
  p_read_ends_done_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_hold_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(lin_addr) && $stable(ill_addr)));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (idle && load_req && read_req) |=> !busy);
endmodule

// File: tb/test_dax_xlate.sv
`timescale 1ns/1ps
module test_dax_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_req = 1'b0;
  logic [17:0] load_word = '0;
  logic        read_req = 1'b0;
  logic        busy, done, ill_addr;
  logic [19:0] lin_addr;
  logic [17:0] bcd_word;

  int checks = 0;
  int errors = 0;
  int exp_lin = 0;
  bit exp_ill = 0;

  always #5 clk = ~clk;

  dax_xlate i_dax_xlate (
    .clk(clk), .rst(rst), .load_req(load_req), .load_word(load_word),
    .read_req(read_req), .busy(busy), .done(done), .ill_addr(ill_addr),
    .lin_addr(lin_addr), .bcd_word(bcd_word));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int to_bcd(input int v);
    return ((v / 100) << 8) | (((v / 10) % 10) << 4) | (v % 10);
  endfunction

  task automatic do_load(input logic [17:0] w);
    int  t, s;
    bit  ok;
    ok = (w[11:8] < 10) && (w[15:12] < 10) && (w[3:0] < 10) && (w[7:4] < 10);
    t  = int'(w[11:8]) + 10 * int'(w[15:12]) + 100 * int'(w[16]);
    s  = int'(w[3:0]) + 10 * int'(w[7:4]);
    ok = ok && (t < 200) && (s < 80);
    @(negedge clk);
    load_req  = 1'b1;
    load_word = w;
    @(posedge clk); #1;
    load_req = 1'b0;
    if (ok) exp_lin = ((t * 80) + s) * 64;
    exp_ill = !ok;
    check(done && (ill_addr == exp_ill) && (lin_addr == 20'(exp_lin)),
          ok ? "R2" : "R3/R4", int'(lin_addr) | (int'(ill_addr) << 24),
          exp_lin | (int'(exp_ill) << 24));
  endtask

  task automatic do_read(input bit poke);
    int n, t, s, dones;
    t = exp_lin / 5120;
    s = (exp_lin % 5120) / 64;
    @(negedge clk);
    read_req = 1'b1;
    n = 0; dones = 0;
    while (n < 400) begin
      @(posedge clk); #1;
      n++;
      if (done) break;
      read_req = 1'b0;
      if (n == 1) check(busy, "R7", busy, 1);
      if (poke && n == 3) begin load_req = 1'b1; load_word = 18'h00101; read_req = 1'b1; end
      else if (poke && n == 4) begin load_req = 1'b0; read_req = 1'b0; end
    end
    load_req = 1'b0; read_req = 1'b0;
    check(n == t + s + 3, "R7", n, t + s + 3);
    check(bcd_word == 18'((to_bcd(t) << 8) | to_bcd(s)), "R6", bcd_word, (to_bcd(t) << 8) | to_bcd(s));
    check(!busy && ill_addr == exp_ill, "R10", ill_addr, exp_ill);
    check(lin_addr == 20'(exp_lin), "R8", lin_addr, exp_lin);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      if (done) dones++;
    end
    check(dones == 0, "R10", dones, 0);
  endtask

  initial begin
    #1_900_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] sec_set [16] = '{8'h00, 8'h01, 8'h09, 8'h10, 8'h45, 8'h79, 8'h80,
                                 8'h99, 8'h0A, 8'hA0, 8'h7F, 8'hFF, 8'h39, 8'h70, 8'h5B, 8'h62};
    logic [8:0] trk_set [8]  = '{9'h000, 9'h001, 9'h099, 9'h100, 9'h199, 9'h0A0, 9'h19F, 9'h1FF};
    repeat (3) @(posedge clk);
    #1;
    check(lin_addr == 0 && bcd_word == 0 && !busy && !done && !ill_addr, "R1",
          lin_addr | bcd_word, 0);
    @(negedge clk); rst = 1'b0;

    // R2/R3/R4: every track code against a sector spread
    for (int tc = 0; tc < 512; tc++)
      for (int j = 0; j < 16; j++)
        do_load({1'b0, 9'(tc), sec_set[j]});
    // R2/R3/R4: every sector code against a track spread
    for (int j = 0; j < 8; j++)
      for (int sc = 0; sc < 256; sc++)
        do_load({1'b0, trk_set[j], 8'(sc)});

    // R5: bit 17 ignored
    do_load(18'h01234);
    do_load(18'h21234);
    check(lin_addr == 20'(((12 * 80) + 34) * 64), "R5", lin_addr, ((12 * 80) + 34) * 64);
    do_load(18'h2FFFF);
    check(lin_addr == 20'(((12 * 80) + 34) * 64), "R5", lin_addr, ((12 * 80) + 34) * 64);

    // R10: done is a single pulse
    @(posedge clk); #1;
    check(!done, "R10", done, 0);

    // R6/R7: read back every track
    for (int t = 0; t < 200; t++) begin
      int s = (t * 7) % 80;
      do_load({1'b0, 9'(to_bcd(t)), 8'(to_bcd(s))});
      do_read(t >= 2 && t % 10 == 3);
    end
    // R10: read after an illegal load keeps the flag
    do_load(18'h00150);
    do_load(18'h0AA00);
    do_read(1'b0);

    // R9: load and read in the same cycle
    @(negedge clk);
    load_req = 1'b1; read_req = 1'b1; load_word = 18'h00502;
    @(posedge clk); #1;
    load_req = 1'b0; read_req = 1'b0;
    check(done && !busy && lin_addr == 20'(((5 * 80) + 2) * 64), "R9", lin_addr, ((5 * 80) + 2) * 64);
    @(posedge clk); #1;
    check(!busy && !done, "R9", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule